// File: doc/BRIEF.md
# Capture/Compare Timer

A 16-bit up-counter paired with two 16-bit registers. The first register is a pure compare value. The second is shared: a control bit makes it either a second compare value or a capture latch that stores the count when the external timer pin shows a selected edge. Each register in compare role drives its own interrupt line, which pulses for the single cycle in which the count equals the register.

The count runs in one of three ways. It can run freely and wrap at FFFFH. It can return to zero on the cycle after it matches the first compare value. It can return to zero on a selected edge of the external pin. The pin passes through a two-stage synchronizer before its edges are detected. The selected edge serves as both the clear event and the capture trigger.

Software reaches the block through a simple write/read port with a 2-bit address. Address 0 is control: bit 0 run, bits 2:1 count mode, bit 3 register-1 role, bits 5:4 edge select. Address 1 is compare register 0 and address 2 is register 1. Address 3 returns the count. The two data registers are not initialised by reset.

Top module: `cc_timer`

## Requirements
- R1: After reset the control register reads 0, the count reads 0 and both interrupt outputs are low.
- R2: With the run bit (control bit 0) clear, the count is forced to 0. With it set, the count rises by one per clock. In mode 00 or 11 (free-running) it wraps from FFFFH to 0000H.
- R3: In mode 01, the count reads 0000H on the cycle after it equals compare register 0.
- R4: In mode 10, a valid edge on the timer pin clears the count. A pin level first applied before clock edge k clears the count at edge k+2.
- R5: Control bits 5:4 pick the valid edge: 00 falling, 01 rising, 10 both, 11 none.
- R6: The interrupt for compare register 0 is high exactly in the cycles where the timer runs and the count equals a non-zero register value.
- R7: A compare value of 0000H matches only when the count reaches zero by wrapping from FFFFH. It does not match at start or after a clear.
- R8: If a compare register is lowered below the current count, no match occurs until the count has wrapped and climbed to the new value.
- R9: With control bit 3 clear, register 1 is a compare register with its own interrupt, which behaves like R6 and R7. With bit 3 set, that interrupt stays low.
- R10: With bit 3 set, a valid pin edge loads register 1 with the count held in the cycle the edge is detected. This is the value before any clear. A software write to register 1 in the same cycle wins.
- R11: A write loads a full 16-bit register in one cycle, and reads return control (in bits 5:0), compare 0, register 1 and the count at addresses 0 to 3. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| tin_i | input | 1 | External timer pin (asynchronous) |
| irq_cmp0_o | output | 1 | Match pulse of compare register 0 |
| irq_cc1_o | output | 1 | Match pulse of register 1 in compare role |

## Verification
The counting function is tried with small compare values in free-running mode, to separate an exact-equality pulse from an off-by-one. It is tried in match-clear mode, where the period shows whether the clear lands one cycle after the match. Pin patterns are applied under every edge selection in clear-on-edge mode and in capture role; these separate rising, falling, both and none and expose the two-cycle synchronizer latency. Two full wrap passes show that a zero compare fires only at the wrap and that a lowered compare waits for the next pass. A long random mix of control, register writes and pin toggles is then checked cycle by cycle against a model in the bench.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'b00,
    MODE_MATCH = 2'b01,
    MODE_EDGE  = 2'b10,
    MODE_FREE2 = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_e;

  // bit 0 run, bits 2:1 mode, bit 3 capture role of register 1, bits 5:4 edge
  typedef struct packed {
    edge_e edge_sel;
    logic  cap1;
    mode_e mode;
    logic  run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP0 = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CC1  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd3;

endpackage

// File: rtl/cc_timer_sync.sv
module cc_timer_sync
  import cc_timer_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_i,
  input  edge_e sel_i,
  output logic  evt_o
);

  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;
  logic            rise;
  logic            fall;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  always_comb begin
    rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    unique case (sel_i)
      EDGE_FALL: evt_o = fall;
      EDGE_RISE: evt_o = rise;
      EDGE_BOTH: evt_o = rise | fall;
      default:   evt_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cc_timer_count.sv
module cc_timer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap_q;
  logic             wrap_d;

  always_comb begin
    if (!run_i || clr_i) begin
      cnt_d  = '0;
      wrap_d = 1'b0;
    end else begin
      cnt_d  = cnt_q + CNT_W'(1);
      wrap_d = &cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan #(
  parameter int CNT_W       = 16,
  parameter bit HAS_CAPTURE = 1'b0
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             cap_mode_i,
  input  logic             cap_evt_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] val_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] val_q;
  logic [CNT_W-1:0] val_d;
  logic             cap_take;
  logic             cmp_on;
  logic             ld_en;

  always_comb begin
    cap_take = HAS_CAPTURE && cap_mode_i && cap_evt_i;
    cmp_on   = !(HAS_CAPTURE && cap_mode_i);
    ld_en    = wr_en_i | cap_take;
    val_d    = wr_en_i ? wdata_i : cnt_i;
  end

  // contents are left undefined by reset
  always_ff @(posedge clk_i) begin
    if (ld_en) begin
      val_q <= val_d;
    end
  end

  always_comb begin
    irq_o = run_i && cmp_on && (cnt_i == val_q) && ((val_q != '0) || wrap_i);
  end

  assign val_o = val_q;

endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic              tin_i,
  output logic              irq_cmp0_o,
  output logic              irq_cc1_o
);

  localparam int NUM_CH = 2;

  logic             rst_meta_q;
  logic             rst_n_s;
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_d;
  logic             ctrl_we;
  logic             evt;
  logic             clr;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [CNT_W-1:0] chan_val [NUM_CH];
  logic             chan_irq [NUM_CH];
  logic [CNT_W-1:0] cmp0_val;
  logic [CNT_W-1:0] cc1_val;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  always_comb begin
    ctrl_we = bus_we_i && (bus_addr_i == ADDR_CTRL);
    ctrl_d  = ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  cc_timer_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .pin_i  (tin_i),
    .sel_i  (ctrl_q.edge_sel),
    .evt_o  (evt)
  );

  always_comb begin
    clr = ((ctrl_q.mode == MODE_MATCH) && chan_irq[0]) ||
          ((ctrl_q.mode == MODE_EDGE)  && evt);
  end

  cc_timer_count #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .run_i  (ctrl_q.run),
    .clr_i  (clr),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    localparam logic [ADDR_W-1:0] CH_ADDR = (g == 0) ? ADDR_CMP0 : ADDR_CC1;
    cc_timer_chan #(
      .CNT_W       (CNT_W),
      .HAS_CAPTURE (g == 1)
    ) u_chan (
      .clk_i      (clk_i),
      .wr_en_i    (bus_we_i && (bus_addr_i == CH_ADDR)),
      .wdata_i    (bus_wdata_i),
      .cap_mode_i (ctrl_q.cap1),
      .cap_evt_i  (evt),
      .run_i      (ctrl_q.run),
      .cnt_i      (cnt),
      .wrap_i     (wrap),
      .val_o      (chan_val[g]),
      .irq_o      (chan_irq[g])
    );
  end

  assign cmp0_val   = chan_val[0];
  assign cc1_val    = chan_val[1];
  assign irq_cmp0_o = chan_irq[0];
  assign irq_cc1_o  = chan_irq[1];

  always_comb begin
    unique case (bus_addr_i)
      ADDR_CTRL: bus_rdata_o = CNT_W'(ctrl_q);
      ADDR_CMP0: bus_rdata_o = cmp0_val;
      ADDR_CC1:  bus_rdata_o = cc1_val;
      default:   bus_rdata_o = cnt;
    endcase
  end

endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_n_s,
  input ctrl_t             ctrl_q,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp0_val,
  input logic [CNT_W-1:0]  cc1_val,
  input logic              evt,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              irq_cmp0_o,
  input logic              irq_cc1_o
);

  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !ctrl_q.run |=> (cnt == '0));

  a_r2_free_step: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (ctrl_q.run && ((ctrl_q.mode == MODE_FREE) || (ctrl_q.mode == MODE_FREE2)))
      |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  a_r3_match_clear: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (ctrl_q.mode == MODE_MATCH && irq_cmp0_o) |=> (cnt == '0));

  a_r4_edge_clear: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (ctrl_q.run && ctrl_q.mode == MODE_EDGE && evt) |=> (cnt == '0));

  a_r6_irq0_equal: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    irq_cmp0_o |-> (ctrl_q.run && cnt == cmp0_val));

  a_r7_zero_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (irq_cmp0_o && cmp0_val == '0) |-> ($past(cnt) == '1));

  a_r9_capture_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ctrl_q.cap1 |-> !irq_cc1_o);

  a_r10_capture_load: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (ctrl_q.cap1 && evt && !(bus_we_i && bus_addr_i == ADDR_CC1))
      |=> (cc1_val == $past(cnt)));

endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n_s    (rst_n_s),
  .ctrl_q     (ctrl_q),
  .cnt        (cnt),
  .cmp0_val   (cmp0_val),
  .cc1_val    (cc1_val),
  .evt        (evt),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .irq_cmp0_o (irq_cmp0_o),
  .irq_cc1_o  (irq_cc1_o)
);

// File: tb/cc_timer_bench.sv
module cc_timer_bench;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        tin;
  logic        irq0;
  logic        irq1;

  int unsigned n_checks;
  int unsigned n_errors;
  int unsigned n_irq0;
  int unsigned n_irq1;
  bit          live;
  string       tag_rd;

  // reference model state
  logic [15:0] m_cnt;
  logic [15:0] m_cmp0;
  logic [15:0] m_cc1;
  logic        m_wrap;
  logic [2:0]  m_s;
  logic [5:0]  m_ctrl;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  cc_timer u_cc_timer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .tin_i       (tin),
    .irq_cmp0_o  (irq0),
    .irq_cc1_o   (irq1)
  );

  function automatic logic exp_irq0();
    return m_ctrl[0] && (m_cnt == m_cmp0) && ((m_cmp0 != 16'h0) || m_wrap);
  endfunction

  function automatic logic exp_irq1();
    return m_ctrl[0] && !m_ctrl[3] && (m_cnt == m_cc1) && ((m_cc1 != 16'h0) || m_wrap);
  endfunction

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {10'h0, m_ctrl};
      2'd1:    return m_cmp0;
      2'd2:    return m_cc1;
      default: return m_cnt;
    endcase
  endfunction

  always @(posedge clk) begin
    logic       rise;
    logic       fall;
    logic       ev;
    logic [1:0] mode;
    if (!live) begin
      m_cnt <= '0; m_wrap <= 1'b0; m_s <= '0; m_ctrl <= '0;
      m_cmp0 <= '0; m_cc1 <= '0;
    end else begin
      rise = m_s[1] & ~m_s[2];
      fall = ~m_s[1] & m_s[2];
      case (m_ctrl[5:4])
        2'd0:    ev = fall;
        2'd1:    ev = rise;
        2'd2:    ev = rise | fall;
        default: ev = 1'b0;
      endcase
      mode = m_ctrl[2:1];
      if (!m_ctrl[0] || (mode == 2'd1 && exp_irq0()) || (mode == 2'd2 && ev)) begin
        m_cnt <= '0; m_wrap <= 1'b0;
      end else begin
        m_cnt <= m_cnt + 16'd1; m_wrap <= &m_cnt;
      end
      m_s <= {m_s[1:0], tin};
      if (bus_we) begin
        case (bus_addr)
          2'd0:    m_ctrl <= bus_wdata[5:0];
          2'd1:    m_cmp0 <= bus_wdata;
          2'd2:    m_cc1  <= bus_wdata;
          default: ;
        endcase
      end
      if (!(bus_we && bus_addr == 2'd2) && m_ctrl[3] && ev) m_cc1 <= m_cnt;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // apply inputs at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic tick(input logic we, input logic [1:0] a, input logic [15:0] d);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    check("R6 irq0", {15'h0, irq0}, {15'h0, exp_irq0()});
    check("R9 irq1", {15'h0, irq1}, {15'h0, exp_irq1()});
    check(tag_rd, bus_rdata, exp_rd(bus_addr));
    if (irq0) n_irq0++;
    if (irq1) n_irq1++;
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) tick(1'b0, a, 16'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    n_checks = 0; n_errors = 0; n_irq0 = 0; n_irq1 = 0; live = 1'b0;
    tag_rd = "R11 read"; v = '0;
    void'($urandom(32'd2718));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0; tin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;

    // R1 reset state
    check("R1 irq0", {15'h0, irq0}, 16'h0);
    check("R1 irq1", {15'h0, irq1}, 16'h0);
    bus_addr = 2'd0; #1 check("R1 ctrl", bus_rdata, 16'h0);
    bus_addr = 2'd3; #1 check("R1 count", bus_rdata, 16'h0);

    // R11 full-width writes, read-only count
    tag_rd = "R11 read";
    tick(1'b1, 2'd1, 16'h1234); idle(1, 2'd1);
    check("R11 cmp0", bus_rdata, 16'h1234);
    tick(1'b1, 2'd2, 16'hBEEF); idle(1, 2'd2);
    check("R11 cc1", bus_rdata, 16'hBEEF);
    tick(1'b1, 2'd3, 16'h5555); idle(1, 2'd3);
    check("R11 count write ignored", bus_rdata, 16'h0);

    // R2 / R6 / R9 free-running with small compares
    tag_rd = "R2 count";
    tick(1'b1, 2'd1, 16'd20);
    tick(1'b1, 2'd2, 16'd25);
    n_irq0 = 0; n_irq1 = 0;
    tick(1'b1, 2'd0, 16'h0001);
    idle(3, 2'd3);
    check("R2 count after 3 clocks", bus_rdata, 16'd3);
    idle(40, 2'd3);
    check("R6 one match pulse", 16'(n_irq0), 16'd1);
    check("R9 compare role pulse", 16'(n_irq1), 16'd1);
    tick(1'b1, 2'd0, 16'h0000); idle(2, 2'd3);
    check("R2 stopped count", bus_rdata, 16'd0);

    // R3 clear on match
    tag_rd = "R3 count";
    tick(1'b1, 2'd1, 16'd10);
    n_irq0 = 0;
    tick(1'b1, 2'd0, 16'h0003);
    begin
      logic [15:0] mx;
      mx = '0;
      for (int i = 0; i < 60; i++) begin
        tick(1'b0, 2'd3, 16'h0);
        if (bus_rdata > mx) mx = bus_rdata;
      end
      check("R3 count peak", mx, 16'd10);
      check("R3 period 11", 16'(n_irq0), 16'd5);
    end

    // R4 clear on rising pin edge, two-cycle latency
    tag_rd = "R4 count";
    tick(1'b1, 2'd0, 16'h0015);
    idle(10, 2'd3);
    tin = 1'b1; tick(1'b0, 2'd3, 16'h0);
    tick(1'b0, 2'd3, 16'h0);
    check("R4 not yet cleared", {15'h0, bus_rdata != 16'h0}, 16'h1);
    tick(1'b0, 2'd3, 16'h0);
    check("R4 cleared at edge k+2", bus_rdata, 16'h0);
    idle(8, 2'd3);

    // R5 each edge selection
    tag_rd = "R5 count";
    for (int s = 0; s < 4; s++) begin
      tick(1'b1, 2'd0, 16'(1 | (2 << 1) | (s << 4)));
      for (int t = 0; t < 4; t++) begin
        idle(6, 2'd3);
        tin = ~tin;
        tick(1'b0, 2'd3, 16'h0);
      end
      idle(5, 2'd3);
    end
    tick(1'b1, 2'd0, 16'h0000);

    // R10 capture on both edges; R9 irq1 silent in capture role
    tag_rd = "R10 capture";
    tick(1'b1, 2'd2, 16'd7);
    n_irq1 = 0;
    tick(1'b1, 2'd0, 16'h0029);
    for (int t = 0; t < 6; t++) begin
      idle(9, 2'd2);
      tin = ~tin; tick(1'b0, 2'd3, 16'h0);
      tick(1'b0, 2'd3, 16'h0); v = bus_rdata;
      tick(1'b0, 2'd2, 16'h0);
      check("R10 captured count", bus_rdata, v);
    end
    check("R9 no pulse in capture role", 16'(n_irq1), 16'd0);
    tin = ~tin; tick(1'b0, 2'd2, 16'h0);
    tick(1'b0, 2'd2, 16'h0);
    tick(1'b1, 2'd2, 16'h0ABC);
    check("R10 write beats capture", bus_rdata, 16'h0ABC);

    // R7 zero compare fires only at wrap
    tag_rd = "R7 count";
    tick(1'b1, 2'd0, 16'h0000);
    tick(1'b1, 2'd1, 16'h0000);
    tick(1'b1, 2'd2, 16'h8000);
    n_irq0 = 0; n_irq1 = 0;
    tick(1'b1, 2'd0, 16'h0001);
    idle(10, 2'd3);
    check("R7 no pulse at start", 16'(n_irq0), 16'd0);
    idle(65990, 2'd3);
    check("R7 one pulse at wrap", 16'(n_irq0), 16'd1);
    check("R9 compare pulse in pass", 16'(n_irq1), 16'd1);

    // R8 lowered compare waits for next pass
    tag_rd = "R8 count";
    tick(1'b1, 2'd1, 16'd100);
    n_irq0 = 0;
    idle(1000, 2'd3);
    check("R8 no early match", 16'(n_irq0), 16'd0);
    idle(65000, 2'd3);
    check("R8 match after wrap", 16'(n_irq0), 16'd1);

    // random mix
    tag_rd = "R11 random read";
    for (int i = 0; i < 15000; i++) begin
      int unsigned r;
      r = $urandom_range(0, 31);
      if ($urandom_range(0, 7) == 0) tin = ~tin;
      if (r == 0) tick(1'b1, 2'd0, 16'($urandom_range(0, 63) | ($urandom_range(0, 7) != 0)));
      else if (r == 1) tick(1'b1, 2'd1, 16'($urandom_range(0, 63)));
      else if (r == 2) tick(1'b1, 2'd2, 16'($urandom_range(0, 63)));
      else tick(1'b0, 2'($urandom_range(0, 3)), 16'h0);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule